// File: doc/BRIEF.md
# Grouped Channel Priority Arbiter

This block decides which DMA channel may use the shared memory port next. Every channel raises a request bit when it has a burst ready. Each channel belongs to one of four fixed priority levels, and the level comes from bits 3:2 of the channel index. Channels 0–3 and 16–19 form the highest level, 0. Channels 4–7 and 20–23 form level 1. Channels 8–11 and 24–27 form level 2. Channels 12–15 and 28–31 form the lowest level, 3.

While no grant is held, the arbiter serves the highest level that has a request. Within that level it rotates round-robin among the requesting channels. After reset each level's rotation starts at its lowest index and moves upward. The grant is registered and held until the granted channel pulses `done_i`.

The outputs are a one-hot grant vector, the granted index and a valid flag. The request and done pins are plain control. There is no valid/ready handshake at the edge: the request is the valid, and the held grant stands in for ready.

The number of wired channels is the parameter `NUM_CH`. Request bits at or above `NUM_CH` are ignored.

Top module: `chan_level_arbiter`

## Requirements
- R1: The priority level of channel i is bits 3:2 of i, and level 0 is the highest. A new grant always goes to a channel in the lowest-numbered level that has an eligible request.
- R2: Within a level, candidates are ordered by ascending index. The new grant goes to the first requesting channel above the last channel granted in that level, wrapping to the lowest requester. After reset the rotation starts at the lowest index. Each level keeps its own rotation state.
- R3: When no grant is held and any eligible request is present at a rising edge, a grant is registered at that edge and is visible right after it.
- R4: While `gnt_valid_o` is 1, `gnt_onehot_o` has exactly bit `gnt_idx_o` set. While it is 0, `gnt_onehot_o` is all zero and `gnt_idx_o` is 0.
- R5: A held grant keeps the same index, whatever the request vector does, until `done_i` is seen.
- R6: `done_i` high at a rising edge while a grant is held clears the grant at that edge. The earliest next grant is registered at the following edge.
- R7: `done_i` while no grant is held has no effect. In that state a request is still granted at the same edge.
- R8: A request bit at an index greater than or equal to `NUM_CH` never produces a grant.
- R9: An active-low reset `rst_n` clears the grant and returns every level's rotation to its starting point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | PORT_W (32) | Per-channel request bits |
| done_i | input | 1 | Granted channel has finished its burst |
| gnt_onehot_o | output | PORT_W (32) | One-hot grant vector |
| gnt_idx_o | output | IDX_W (5) | Index of the granted channel |
| gnt_valid_o | output | 1 | A grant is held |

## Verification
A grant is due one rising edge after a request is present with the arbiter idle. The release is due one edge after `done_i` is seen with a grant held. No result ever needs more than one edge. The bench therefore changes inputs on the falling edge and reads outputs on the next falling edge. Every check thus lands exactly one register stage after its stimulus. The expected grant comes from an arithmetic model in the bench. That model keeps its own per-level rotation and replays level-0-first, ascending-index selection over single-channel sweeps, full-vector rotations and a few hundred random vectors.

// File: rtl/chan_arb_pkg.sv
package chan_arb_pkg;
  // Level of a channel: a field of its index
  function automatic int unsigned chan_level(input int unsigned idx,
                                             input int unsigned lsb,
                                             input int unsigned w);
    return (idx >> lsb) & ((32'd1 << w) - 32'd1);
  endfunction
endpackage

// File: rtl/chan_arb_elig.sv
module chan_arb_elig #(
  parameter int PORT_W  = 32,
  parameter int NUM_CH  = 32,
  parameter int LVL_LSB = 2,
  parameter int LVL_W   = 2,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic [PORT_W-1:0]         req_i,
  output logic [NUM_LVL*PORT_W-1:0] lvl_req_o,
  output logic [PORT_W-1:0]         elig_o
);
  import chan_arb_pkg::*;

  // Channels at or above NUM_CH are never eligible (R8)
  for (genvar i = 0; i < PORT_W; i++) begin : g_ch
    if (i < NUM_CH) begin : g_live
      assign elig_o[i] = req_i[i];
    end else begin : g_dead
      assign elig_o[i] = 1'b0;
    end
  end

  // Split eligible requests by priority level
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
      if (chan_level(i, LVL_LSB, LVL_W) == l) begin : g_in
        assign lvl_req_o[l*PORT_W+i] = elig_o[i];
      end else begin : g_out
        assign lvl_req_o[l*PORT_W+i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/chan_arb_level_rr.sv
module chan_arb_level_rr #(
  parameter int PORT_W = 32,
  localparam int IDX_W = $clog2(PORT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] lvl_req_i,
  input  logic              take_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  pick_o
);
  logic [IDX_W-1:0]  last_q;
  logic [PORT_W-1:0] above;
  logic [IDX_W-1:0]  pick_hi, pick_any;
  logic              found_hi;

  // Requests strictly above the last granted index in this level
  always_comb begin
    for (int i = 0; i < PORT_W; i++) begin
      above[i] = lvl_req_i[i] && (i > int'(last_q));
    end
  end

  // Lowest set bit of each candidate set (scan high to low, keep last)
  always_comb begin
    pick_hi  = '0;
    pick_any = '0;
    found_hi = 1'b0;
    for (int i = PORT_W - 1; i >= 0; i--) begin
      if (above[i]) begin
        pick_hi  = IDX_W'(i);
        found_hi = 1'b1;
      end
      if (lvl_req_i[i]) begin
        pick_any = IDX_W'(i);
      end
    end
  end

  assign hit_o  = |lvl_req_i;
  assign pick_o = found_hi ? pick_hi : pick_any;

  // Rotation state: reset to top index so the first scan starts at 0 (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IDX_W'(PORT_W - 1);
    end else if (take_i) begin
      last_q <= pick_o;
    end
  end

  // R2: the chosen channel is a requester of this level
  p_pick_member_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> lvl_req_i[pick_o]);

  // R2: after a take the rotation remembers the granted channel
  p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (last_q == $past(pick_o)));
endmodule

// File: rtl/chan_arb_level_sel.sv
module chan_arb_level_sel #(
  parameter int NUM_LVL = 4,
  parameter int IDX_W   = 5,
  localparam int SEL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic [NUM_LVL-1:0]       hit_i,
  input  logic [NUM_LVL*IDX_W-1:0] pick_i,
  output logic                     sel_valid_o,
  output logic [SEL_W-1:0]         sel_lvl_o,
  output logic [IDX_W-1:0]         sel_idx_o
);
  // Lowest level with a hit wins (R1)
  always_comb begin
    sel_lvl_o = '0;
    sel_idx_o = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (hit_i[l]) begin
        sel_lvl_o = SEL_W'(l);
        sel_idx_o = pick_i[l*IDX_W +: IDX_W];
      end
    end
  end

  assign sel_valid_o = |hit_i;

  // R1: no hit exists in any level above the selected one
  always_comb begin
    if (sel_valid_o) begin
      a_lvl_first_r1: assert ((hit_i & ((NUM_LVL'(1) << sel_lvl_o) - NUM_LVL'(1))) == '0);
    end
  end
endmodule

// File: rtl/chan_level_arbiter.sv
module chan_level_arbiter #(
  parameter int PORT_W  = 32,
  parameter int NUM_CH  = 32,
  parameter int LVL_LSB = 2,
  parameter int LVL_W   = 2,
  localparam int IDX_W   = $clog2(PORT_W),
  localparam int NUM_LVL = 1 << LVL_W,
  localparam int SEL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] req_i,
  input  logic              done_i,
  output logic [PORT_W-1:0] gnt_onehot_o,
  output logic [IDX_W-1:0]  gnt_idx_o,
  output logic              gnt_valid_o
);
  import chan_arb_pkg::*;

  logic [NUM_LVL*PORT_W-1:0] lvl_req;
  logic [PORT_W-1:0]         elig;
  logic [NUM_LVL-1:0]        hit;
  logic [NUM_LVL*IDX_W-1:0]  pick;
  logic [NUM_LVL-1:0]        take;
  logic                      sel_valid;
  logic [SEL_W-1:0]          sel_lvl;
  logic [IDX_W-1:0]          sel_idx;
  logic                      issue;
  logic                      gnt_valid_q;
  logic [IDX_W-1:0]          gnt_idx_q;

  chan_arb_elig #(
    .PORT_W(PORT_W), .NUM_CH(NUM_CH), .LVL_LSB(LVL_LSB), .LVL_W(LVL_W)
  ) u_elig (
    .req_i     (req_i),
    .lvl_req_o (lvl_req),
    .elig_o    (elig)
  );

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    assign take[l] = issue && (sel_lvl == SEL_W'(l));
    chan_arb_level_rr #(.PORT_W(PORT_W)) u_rr (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_req_i (lvl_req[l*PORT_W +: PORT_W]),
      .take_i    (take[l]),
      .hit_o     (hit[l]),
      .pick_o    (pick[l*IDX_W +: IDX_W])
    );
  end

  chan_arb_level_sel #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) u_sel (
    .hit_i       (hit),
    .pick_i      (pick),
    .sel_valid_o (sel_valid),
    .sel_lvl_o   (sel_lvl),
    .sel_idx_o   (sel_idx)
  );

  // Arbitrate only while no grant is held; done_i is ignored when idle (R7)
  assign issue = !gnt_valid_q && sel_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid_q <= 1'b0;
      gnt_idx_q   <= '0;
    end else if (issue) begin
      gnt_valid_q <= 1'b1;
      gnt_idx_q   <= sel_idx;
    end else if (gnt_valid_q && done_i) begin
      gnt_valid_q <= 1'b0;
      gnt_idx_q   <= '0;
    end
  end

  always_comb begin
    gnt_onehot_o = '0;
    if (gnt_valid_q) begin
      gnt_onehot_o[gnt_idx_q] = 1'b1;
    end
  end

  assign gnt_idx_o   = gnt_idx_q;
  assign gnt_valid_o = gnt_valid_q;

  // Mask of channels whose level is strictly higher priority than lvl
  function automatic logic [PORT_W-1:0] higher_mask(input int unsigned lvl);
    logic [PORT_W-1:0] m;
    for (int i = 0; i < PORT_W; i++) begin
      m[i] = chan_level(i, LVL_LSB, LVL_W) < lvl;
    end
    return m;
  endfunction

  p_level_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid_q) |->
      (($past(req_i) & higher_mask(chan_level(int'(gnt_idx_q), LVL_LSB, LVL_W))
        & {PORT_W{1'b1}} >> (PORT_W - NUM_CH)) == '0));

  p_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid_o && (|elig)) |=> gnt_valid_o);

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_onehot_o) && (gnt_valid_o == (|gnt_onehot_o)));

  p_onehot_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> gnt_onehot_o[gnt_idx_o]);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && !done_i) |=> (gnt_valid_o && $stable(gnt_idx_o)));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && done_i) |=> !gnt_valid_o);

  p_idle_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid_o && !(|elig)) |=> !gnt_valid_o);

  p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> (int'(gnt_idx_o) < NUM_CH));
endmodule

// File: tb/chan_level_arbiter_bench.sv
module chan_level_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 32;
  localparam int NCH_NARROW = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req = '0;
  logic        done = 1'b0;
  logic [31:0] gnt_oh;
  logic [4:0]  gnt_idx;
  logic        gnt_valid;

  logic [31:0] req_n = '0;
  logic        done_n = 1'b0;
  logic [31:0] gnt_oh_n;
  logic [4:0]  gnt_idx_n;
  logic        gnt_valid_n;

  int checks = 0;
  int failures = 0;
  int last_m[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_level_arbiter #(.NUM_CH(NCH)) u_chan_level_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done),
    .gnt_onehot_o(gnt_oh), .gnt_idx_o(gnt_idx), .gnt_valid_o(gnt_valid)
  );

  chan_level_arbiter #(.NUM_CH(NCH_NARROW)) u_chan_level_arbiter_narrow (
    .clk(clk), .rst_n(rst_n), .req_i(req_n), .done_i(done_n),
    .gnt_onehot_o(gnt_oh_n), .gnt_idx_o(gnt_idx_n), .gnt_valid_o(gnt_valid_n)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int l = 0; l < 4; l++) last_m[l] = 31;
  endtask

  // Level-first, then first requester above the level's last grant, else lowest
  task automatic model_pick(input logic [31:0] r, input int num, output int p);
    p = -1;
    for (int l = 0; l < 4; l++) begin
      int first_hi = -1;
      int first_any = -1;
      if (p < 0) begin
        for (int i = 0; i < num; i++) begin
          if (((i >> 2) & 3) == l && r[i]) begin
            if (first_any < 0) first_any = i;
            if (i > last_m[l] && first_hi < 0) first_hi = i;
          end
        end
        if (first_any >= 0) begin
          p = (first_hi >= 0) ? first_hi : first_any;
          last_m[l] = p;
        end
      end
    end
  endtask

  // Called at a falling edge with no grant held and done low
  task automatic run_trial(input logic [31:0] r, input string tag);
    int exp;
    model_pick(r, NCH, exp);
    req = r;
    @(negedge clk);
    if (exp < 0) begin
      check(gnt_valid == 1'b0, {tag, " R3 no-request"}, gnt_valid, 0);
      req = '0;
      return;
    end
    check(gnt_valid == 1'b1, {tag, " R3 grant due"}, gnt_valid, 1);
    check(gnt_idx == 5'(exp), {tag, " R1/R2 index"}, gnt_idx, exp);
    check(gnt_oh == (32'd1 << exp), {tag, " R4 onehot"}, gnt_oh, 32'd1 << exp);
    req = $urandom;
    @(negedge clk);
    check(gnt_valid && gnt_idx == 5'(exp), {tag, " R5 hold"}, gnt_idx, exp);
    req = '0;
    done = 1'b1;
    @(negedge clk);
    check(gnt_valid == 1'b0 && gnt_oh == '0 && gnt_idx == '0, {tag, " R6 release"},
          {gnt_valid, gnt_oh}, 0);
    done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    @(negedge clk);
    // R9: reset state
    check(gnt_valid == 0 && gnt_oh == 0 && gnt_idx == 0, "R9 reset outputs", gnt_oh, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: done while idle has no effect
    done = 1'b1;
    @(negedge clk);
    check(gnt_valid == 1'b0, "R7 done idle", gnt_valid, 0);
    // R7: request with done high while idle still granted
    req = 32'h0000_0100;
    @(negedge clk);
    check(gnt_valid && gnt_idx == 5'd8, "R7 grant with done high", gnt_idx, 8);
    req = '0;
    @(negedge clk);
    check(gnt_valid == 1'b0, "R6 release with held done", gnt_valid, 0);
    done = 1'b0;
    last_m[2] = 8;

    // R1/R2: single channel sweep
    for (int c = 0; c < NCH; c++) run_trial(32'd1 << c, "sweep single");
    // R1: pairs across levels
    for (int a = 0; a < NCH; a++) run_trial((32'd1 << a) | (32'd1 << ((a * 7 + 5) % NCH)), "pair");
    // R2: full vector rotation in level 0
    for (int k = 0; k < 20; k++) run_trial(32'hFFFF_FFFF, "all rr");
    // R2: level 3 only rotation
    for (int k = 0; k < 12; k++) run_trial(32'hF000_F000, "lvl3 rr");
    // R2: level 1 and 2 rotation independence
    for (int k = 0; k < 10; k++) run_trial(32'h00F0_0F00, "lvl2 hidden");
    // Random vectors
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r = $urandom;
      if (k % 3 == 0) r = r & $urandom & $urandom;
      run_trial(r, "random");
    end
    run_trial(32'h0, "empty");

    // R9: reset mid-run restores rotation start
    rst_n = 1'b0;
    @(negedge clk);
    check(gnt_valid == 1'b0, "R9 reset clears", gnt_valid, 0);
    rst_n = 1'b1;
    model_reset();
    run_trial(32'h0003_0003, "R9 restart");

    // R8: unwired channels in narrow instance
    req_n = 32'hFFF0_0000;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(gnt_valid_n == 1'b0 && gnt_oh_n == '0, "R8 unused never granted", gnt_oh_n, 0);
    end
    req_n = 32'h0208_0000;
    @(negedge clk);
    check(gnt_valid_n && gnt_idx_n == 5'd19, "R8 live channel granted", gnt_idx_n, 19);
    req_n = '0;
    done_n = 1'b1;
    @(negedge clk);
    check(gnt_valid_n == 1'b0, "R6 narrow release", gnt_valid_n, 0);
    done_n = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule